// File: doc/BRIEF.md
# Serial Interface Host Registers and Interrupt Logic

This block is the processor side of an asynchronous serial communications interface. It decodes a three-line chip select, a register select, a read/write line and an enable strobe. It keeps a write-only control word and builds a read-only status byte. It drives an active-low interrupt request and the active-low request-to-send line, and it tracks the clear-to-send and carrier-detect modem inputs. A separate transmitter and receiver, which are not part of this block, exchange single-cycle strobes with it. The transmitter gets a data-written pulse with the byte and returns a loaded pulse. The receiver delivers a character pulse with its error flags and gets a receive-data-read pulse back.

An access is captured while the strobe is high and the device is selected. It takes effect at the first clock edge after the strobe falls. Read data is driven combinationally while the read access is in progress. Writing the control word with the divide field set to 11 performs a master reset and leaves the control word as it was. A synchronous power-on reset puts the block in a cold state. In that state request-to-send and the interrupt line stay inactive until the first master reset.

Top module: `acia_host_regs`

## Requirements
- R1: An access is accepted only while sel_a=1, sel_b=1, sel_n=0 and strobe=1. Otherwise rdata is 0 and no register changes.
- R2: A captured access takes effect at the first clock edge after strobe falls. With reg_sel=0, a write (rd_wr=0) loads the control word and a read (rd_wr=1) returns status. With reg_sel=1, a write loads transmit data and a read returns receive data.
- R3: Control bits 1:0 select the divide on clk_div (00 = 1, 01 = 16, 10 = 64), and bits 4:2 appear on word_fmt. The value 11 in bits 1:0 is a master reset and leaves the whole control word unchanged.
- R4: Control bits 6:5 set the transmit mode. 00 gives rts_n=0 with no transmit interrupt. 01 gives rts_n=0 with the transmit interrupt enabled. 10 gives rts_n=1. 11 gives rts_n=0 with tx_break=1.
- R5: Control bit 7 enables the receive interrupt. Its sources are receive-full, overrun and latched carrier loss.
- R6: Status bit order from bit 0 to bit 7 is: receive full, transmit empty, carrier lost, clear-to-send high, framing error, overrun, parity error, interrupt active. Bit 7 is 1 exactly when irq_n is 0.
- R7: While cts_n=1, status bit 3 reads 1 and the transmit-empty bit reads 0.
- R8: A rising edge on dcd_n latches status bit 2 and raises the interrupt when bit 7 of the control word is set. The latch clears only on a data read that follows a status read made after the edge, or on master reset. After that, bit 2 follows dcd_n.
- R9: A character pulse with receive-full clear loads the byte and the FE/PE flags and sets receive-full. With receive-full set, the pulse sets overrun and the stored byte is kept. A data read returns the byte, pulses rx_read, and clears receive-full, overrun, FE and PE.
- R10: A data write puts the byte on tx_byte, pulses tx_wr and clears transmit-empty. A tx_taken pulse sets transmit-empty again.
- R11: Master reset clears receive-full, overrun and the carrier latch, and sets transmit-empty. It has no effect on the clear-to-send status bit.
- R12: After rst, rts_n and irq_n stay at 1 until the first master reset, whatever the control word holds.
- R13: irq_n is 0 exactly while an enabled source is active. A data read releases a receive-full interrupt, and a data write releases a transmit-empty interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| sel_a | input | 1 | Chip select, active high |
| sel_b | input | 1 | Chip select, active high |
| sel_n | input | 1 | Chip select, active low |
| strobe | input | 1 | Access enable strobe |
| reg_sel | input | 1 | 0 = control/status, 1 = data |
| rd_wr | input | 1 | 1 = read, 0 = write |
| wdata | input | 8 | Write data from the processor |
| rdata | output | 8 | Read data to the processor |
| irq_n | output | 1 | Interrupt request, active low |
| rts_n | output | 1 | Request to send, active low |
| cts_n | input | 1 | Clear to send, active low |
| dcd_n | input | 1 | Carrier detect, active low |
| clk_div | output | 2 | Selected divide code |
| word_fmt | output | 3 | Selected character format code |
| tx_break | output | 1 | Transmitter break request |
| tx_wr | output | 1 | Pulse: transmit byte written |
| tx_byte | output | 8 | Last byte written for transmission |
| tx_taken | input | 1 | Pulse: transmitter loaded the byte |
| rx_valid | input | 1 | Pulse: character received |
| rx_char | input | 8 | Received character |
| rx_frame_err | input | 1 | Framing error of the received character |
| rx_par_err | input | 1 | Parity error of the received character |
| rx_read | output | 1 | Pulse: receive data read |

## Verification
The properties assume that all inputs are synchronous to clk. They also assume that strobe is low for at least one cycle between two accesses, so that each capture commits exactly once. A transmit write and a tx_taken pulse in the same cycle are resolved in favour of the write, and the transmit-empty properties rely on that. The bench drives every input on the falling clock edge. It drops strobe together with the selects and holds strobe low for a full cycle after every access. It never asserts tx_taken in the same cycle as a data write.

// File: rtl/acia_pkg.sv
package acia_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        DIV_1      = 2'b00,
        DIV_16     = 2'b01,
        DIV_64     = 2'b10,
        DIV_MRESET = 2'b11
    } div_sel_e;

    typedef enum logic [1:0] {
        TXM_QUIET   = 2'b00,
        TXM_IRQ     = 2'b01,
        TXM_RTS_OFF = 2'b10,
        TXM_BREAK   = 2'b11
    } tx_mode_e;

    // field order follows the bit positions of the control byte (msb first)
    typedef struct packed {
        logic       rx_irq_en;
        tx_mode_e   tx_mode;
        logic [2:0] fmt;
        div_sel_e   div;
    } ctrl_word_t;

    // field order follows the bit positions of the status byte (msb first)
    typedef struct packed {
        logic irq;
        logic par_err;
        logic overrun;
        logic frame_err;
        logic cts;
        logic carrier;
        logic tx_empty;
        logic rx_full;
    } status_word_t;

    typedef struct packed {
        logic wr_ctrl;
        logic rd_stat;
        logic wr_data;
        logic rd_data;
    } bus_op_t;

    function automatic logic is_mreset(input logic [BYTE_W-1:0] b);
        return div_sel_e'(b[1:0]) == DIV_MRESET;
    endfunction

    function automatic logic tx_irq_on(input tx_mode_e m);
        return m == TXM_IRQ;
    endfunction

endpackage

// File: rtl/acia_bus_decode.sv
module acia_bus_decode
    import acia_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_a,
    input  logic              sel_b,
    input  logic              sel_n,
    input  logic              strobe,
    input  logic              reg_sel,
    input  logic              rd_wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic              active,
    output bus_op_t           op,
    output logic [BYTE_W-1:0] wbyte
);

    logic              cap_v;
    logic              cap_rs;
    logic              cap_rw;
    logic [BYTE_W-1:0] cap_d;
    logic              fire;

    assign active = sel_a & sel_b & ~sel_n & strobe;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_v  <= 1'b0;
            cap_rs <= 1'b0;
            cap_rw <= 1'b1;
            cap_d  <= '0;
        end else begin
            cap_v <= active;
            if (active) begin
                cap_rs <= reg_sel;
                cap_rw <= rd_wr;
                cap_d  <= wdata;
            end
        end
    end

    // commit in the cycle after the strobe has dropped
    assign fire = cap_v & ~strobe;

    always_comb begin
        op.wr_ctrl = fire & ~cap_rs & ~cap_rw;
        op.rd_stat = fire & ~cap_rs &  cap_rw;
        op.wr_data = fire &  cap_rs & ~cap_rw;
        op.rd_data = fire &  cap_rs &  cap_rw;
    end

    assign wbyte = cap_d;

endmodule

// File: rtl/acia_ctrl_reg.sv
module acia_ctrl_reg
    import acia_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wbyte,
    output ctrl_word_t        ctrl,
    output logic              mreset,
    output logic              cold
);

    assign mreset = wr & is_mreset(wbyte);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            cold <= 1'b1;
        end else if (mreset) begin
            cold <= 1'b0;
        end else if (wr) begin
            ctrl <= ctrl_word_t'(wbyte);
        end
    end

endmodule

// File: rtl/acia_status_core.sv
module acia_status_core
    import acia_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mreset,
    input  bus_op_t           op,
    input  logic              cold,
    input  logic              rx_ie,
    input  logic              tx_ie,
    input  logic              cts_n,
    input  logic              dcd_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_char,
    input  logic              rx_frame_err,
    input  logic              rx_par_err,
    input  logic              tx_taken,
    output status_word_t      stat,
    output logic [BYTE_W-1:0] rdr,
    output logic              irq
);

    logic rx_full, overrun, fe, pe, tx_empty;
    logic dcd_lost, stat_seen, dcd_q;
    logic dcd_rise;

    assign dcd_rise = dcd_n & ~dcd_q;

    always_ff @(posedge clk) begin
        if (rst || mreset) begin
            rx_full   <= 1'b0;
            overrun   <= 1'b0;
            fe        <= 1'b0;
            pe        <= 1'b0;
            tx_empty  <= 1'b1;
            dcd_lost  <= 1'b0;
            stat_seen <= 1'b0;
            if (rst) rdr <= '0;
        end else begin
            if (op.rd_data) begin
                rx_full <= 1'b0;
                overrun <= 1'b0;
                fe      <= 1'b0;
                pe      <= 1'b0;
                if (stat_seen) begin
                    dcd_lost  <= 1'b0;
                    stat_seen <= 1'b0;
                end
            end
            if (op.rd_stat && dcd_lost) stat_seen <= 1'b1;
            if (rx_valid) begin
                if (rx_full && !op.rd_data) begin
                    overrun <= 1'b1;
                end else begin
                    rdr     <= rx_char;
                    fe      <= rx_frame_err;
                    pe      <= rx_par_err;
                    rx_full <= 1'b1;
                end
            end
            if (tx_taken)   tx_empty <= 1'b1;
            if (op.wr_data) tx_empty <= 1'b0;
            if (dcd_rise) begin
                dcd_lost  <= 1'b1;
                stat_seen <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        dcd_q <= dcd_n;
    end

    assign irq = ~cold & ((rx_ie & (rx_full | overrun | dcd_lost)) |
                          (tx_ie & tx_empty & ~cts_n));

    always_comb begin
        stat.rx_full   = rx_full;
        stat.tx_empty  = tx_empty & ~cts_n;
        stat.carrier   = dcd_lost | dcd_n;
        stat.cts       = cts_n;
        stat.frame_err = fe;
        stat.overrun   = overrun;
        stat.par_err   = pe;
        stat.irq       = irq;
    end

endmodule

// File: rtl/acia_host_regs.sv
module acia_host_regs
    import acia_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_a,
    input  logic              sel_b,
    input  logic              sel_n,
    input  logic              strobe,
    input  logic              reg_sel,
    input  logic              rd_wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              irq_n,
    output logic              rts_n,
    input  logic              cts_n,
    input  logic              dcd_n,
    output logic [1:0]        clk_div,
    output logic [2:0]        word_fmt,
    output logic              tx_break,
    output logic              tx_wr,
    output logic [BYTE_W-1:0] tx_byte,
    input  logic              tx_taken,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_char,
    input  logic              rx_frame_err,
    input  logic              rx_par_err,
    output logic              rx_read
);

    logic              active;
    bus_op_t           op;
    logic [BYTE_W-1:0] wbyte;
    ctrl_word_t        ctrl;
    logic              mreset;
    logic              cold;
    status_word_t      stat_w;
    logic [BYTE_W-1:0] rdr;
    logic              irq;
    logic [BYTE_W-1:0] tdr;

    acia_bus_decode u_bus (
        .clk     (clk),
        .rst     (rst),
        .sel_a   (sel_a),
        .sel_b   (sel_b),
        .sel_n   (sel_n),
        .strobe  (strobe),
        .reg_sel (reg_sel),
        .rd_wr   (rd_wr),
        .wdata   (wdata),
        .active  (active),
        .op      (op),
        .wbyte   (wbyte)
    );

    acia_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr     (op.wr_ctrl),
        .wbyte  (wbyte),
        .ctrl   (ctrl),
        .mreset (mreset),
        .cold   (cold)
    );

    acia_status_core u_stat (
        .clk          (clk),
        .rst          (rst),
        .mreset       (mreset),
        .op           (op),
        .cold         (cold),
        .rx_ie        (ctrl.rx_irq_en),
        .tx_ie        (tx_irq_on(ctrl.tx_mode)),
        .cts_n        (cts_n),
        .dcd_n        (dcd_n),
        .rx_valid     (rx_valid),
        .rx_char      (rx_char),
        .rx_frame_err (rx_frame_err),
        .rx_par_err   (rx_par_err),
        .tx_taken     (tx_taken),
        .stat         (stat_w),
        .rdr          (rdr),
        .irq          (irq)
    );

    always_ff @(posedge clk) begin
        if (rst)             tdr <= '0;
        else if (op.wr_data) tdr <= wbyte;
    end

    assign rdata    = (active & rd_wr) ? (reg_sel ? rdr : BYTE_W'(stat_w)) : '0;
    assign irq_n    = ~irq;
    assign rts_n    = cold | (ctrl.tx_mode == TXM_RTS_OFF);
    assign tx_break = (ctrl.tx_mode == TXM_BREAK);
    assign clk_div  = ctrl.div;
    assign word_fmt = ctrl.fmt;
    assign tx_wr    = op.wr_data;
    assign tx_byte  = tdr;
    assign rx_read  = op.rd_data;

endmodule

// File: rtl/acia_host_regs_chk.sv
module acia_host_regs_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_data,
    input logic       rd_data,
    input logic       mreset,
    input logic       cold,
    input logic       rx_valid,
    input logic       tx_taken,
    input logic       cts_n,
    input logic [7:0] stat,
    input logic [1:0] clk_div,
    input logic       rts_n,
    input logic       irq_n
);

    p_mreset_clears_r11: assert property (@(posedge clk) disable iff (rst)
        mreset |=> (!stat[0] && !stat[5]));

    p_mreset_keeps_ctrl_r3: assert property (@(posedge clk) disable iff (rst)
        mreset |=> $stable(clk_div));

    p_cts_masks_empty_r7: assert property (@(posedge clk) disable iff (rst)
        cts_n |-> (!stat[1] && stat[3]));

    p_read_clears_full_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_data && !rx_valid) |=> (!stat[0] && !stat[5]));

    p_rx_sets_full_r9: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !mreset) |=> stat[0]);

    p_write_clears_empty_r10: assert property (@(posedge clk) disable iff (rst)
        wr_data |=> !stat[1]);

    p_taken_sets_empty_r10: assert property (@(posedge clk) disable iff (rst)
        (tx_taken && !wr_data && !mreset) |=> (stat[1] || cts_n));

    p_cold_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        cold |-> (rts_n && irq_n));

endmodule

bind acia_host_regs acia_host_regs_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .wr_data  (op.wr_data),
    .rd_data  (op.rd_data),
    .mreset   (mreset),
    .cold     (cold),
    .rx_valid (rx_valid),
    .tx_taken (tx_taken),
    .cts_n    (cts_n),
    .stat     (stat_w),
    .clk_div  (clk_div),
    .rts_n    (rts_n),
    .irq_n    (irq_n)
);

// File: tb/acia_host_regs_tb.sv
module acia_host_regs_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_a = 1'b0, sel_b = 1'b0, sel_n = 1'b1, strobe = 1'b0;
    logic       reg_sel = 1'b0, rd_wr = 1'b1;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq_n, rts_n;
    logic       cts_n = 1'b0, dcd_n = 1'b0;
    logic [1:0] clk_div;
    logic [2:0] word_fmt;
    logic       tx_break, tx_wr, rx_read;
    logic [7:0] tx_byte;
    logic       tx_taken = 1'b0, rx_valid = 1'b0;
    logic [7:0] rx_char = '0;
    logic       rx_frame_err = 1'b0, rx_par_err = 1'b0;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;
    logic [7:0] q;
    logic seen_rx_read, seen_tx_wr;

    always #2 clk = ~clk;

    acia_host_regs dut_i (
        .clk(clk), .rst(rst), .sel_a(sel_a), .sel_b(sel_b), .sel_n(sel_n),
        .strobe(strobe), .reg_sel(reg_sel), .rd_wr(rd_wr), .wdata(wdata),
        .rdata(rdata), .irq_n(irq_n), .rts_n(rts_n), .cts_n(cts_n),
        .dcd_n(dcd_n), .clk_div(clk_div), .word_fmt(word_fmt),
        .tx_break(tx_break), .tx_wr(tx_wr), .tx_byte(tx_byte),
        .tx_taken(tx_taken), .rx_valid(rx_valid), .rx_char(rx_char),
        .rx_frame_err(rx_frame_err), .rx_par_err(rx_par_err), .rx_read(rx_read)
    );

    // {control byte, clk_div, word_fmt, rts_n, tx_break}
    localparam logic [14:0] VEC [6] = '{
        {8'h00, 2'd0, 3'd0, 1'b0, 1'b0},
        {8'h15, 2'd1, 3'd5, 1'b0, 1'b0},
        {8'h4A, 2'd2, 3'd2, 1'b1, 1'b0},
        {8'h7C, 2'd0, 3'd7, 1'b0, 1'b1},
        {8'h2D, 2'd1, 3'd3, 1'b0, 1'b0},
        {8'hFF, 2'd1, 3'd3, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus(input logic rs, input logic rw, input logic [7:0] d,
                       input logic hit, output logic [7:0] rd);
        @(negedge clk);
        sel_a = 1'b1; sel_b = 1'b1; sel_n = ~hit;
        reg_sel = rs; rd_wr = rw; wdata = d; strobe = 1'b1;
        @(negedge clk);
        rd = rdata;
        @(negedge clk);
        strobe = 1'b0; sel_a = 1'b0; sel_b = 1'b0; sel_n = 1'b1;
        #1;
        seen_rx_read = rx_read;
        seen_tx_wr = tx_wr;
        @(negedge clk);
    endtask

    task automatic wr_ctrl(input logic [7:0] d);
        logic [7:0] tmp;
        bus(1'b0, 1'b0, d, 1'b1, tmp);
    endtask

    task automatic rd_stat(output logic [7:0] s);
        bus(1'b0, 1'b1, 8'h00, 1'b1, s);
    endtask

    task automatic rx_push(input logic [7:0] c, input logic f, input logic p);
        @(negedge clk);
        rx_valid = 1'b1; rx_char = c; rx_frame_err = f; rx_par_err = p;
        @(negedge clk);
        rx_valid = 1'b0; rx_frame_err = 1'b0; rx_par_err = 1'b0;
    endtask

    task automatic settle(input logic d);
        @(negedge clk);
        dcd_n = d;
        @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset and cold state (R6, R12, R1)
        chk("R12 rts_n after rst", {7'd0, rts_n}, 8'h01);
        chk("R12 irq_n after rst", {7'd0, irq_n}, 8'h01);
        chk("R1 rdata idle", rdata, 8'h00);
        rd_stat(q);
        chk("R6 status after rst", q, 8'h02);

        wr_ctrl(8'h81);
        chk("R12 rts_n held while cold", {7'd0, rts_n}, 8'h01);
        rx_push(8'h5A, 1'b0, 1'b0);
        chk("R12 irq_n held while cold", {7'd0, irq_n}, 8'h01);
        rd_stat(q);
        chk("R2 status while cold", q, 8'h03);

        wr_ctrl(8'h03);
        chk("R12 rts_n after first master reset", {7'd0, rts_n}, 8'h00);
        chk("R3 divide kept by master reset", {6'd0, clk_div}, 8'h01);
        rd_stat(q);
        chk("R11 status after master reset", q, 8'h02);

        // control vectors (R3, R4)
        foreach (VEC[i]) begin
            wr_ctrl(VEC[i][14:7]);
            chk("R3 clk_div", {6'd0, clk_div}, {6'd0, VEC[i][6:5]});
            chk("R3 word_fmt", {5'd0, word_fmt}, {5'd0, VEC[i][4:2]});
            chk("R4 rts_n", {7'd0, rts_n}, {7'd0, VEC[i][1]});
            chk("R4 tx_break", {7'd0, tx_break}, {7'd0, VEC[i][0]});
        end

        // deselected access (R1)
        bus(1'b0, 1'b0, 8'h4A, 1'b0, q);
        chk("R1 deselected write ignored rts_n", {7'd0, rts_n}, 8'h00);
        chk("R1 deselected write ignored fmt", {5'd0, word_fmt}, 8'h03);
        bus(1'b0, 1'b1, 8'h00, 1'b0, q);
        chk("R1 deselected read data", q, 8'h00);

        // receive path (R5, R9, R13)
        wr_ctrl(8'h80);
        chk("R13 irq idle", {7'd0, irq_n}, 8'h01);
        rx_push(8'hA5, 1'b1, 1'b0);
        chk("R5 irq on receive full", {7'd0, irq_n}, 8'h00);
        rd_stat(q);
        chk("R6 status with char", q, 8'h93);
        rx_push(8'h3C, 1'b0, 1'b1);
        rd_stat(q);
        chk("R9 overrun status", q, 8'hB3);
        bus(1'b1, 1'b1, 8'h00, 1'b1, q);
        chk("R9 data read keeps first char", q, 8'hA5);
        chk("R9 rx_read pulse", {7'd0, seen_rx_read}, 8'h01);
        chk("R13 irq released by data read", {7'd0, irq_n}, 8'h01);
        rd_stat(q);
        chk("R9 status after data read", q, 8'h02);

        // transmit path (R10, R13)
        wr_ctrl(8'h20);
        chk("R13 irq on transmit empty", {7'd0, irq_n}, 8'h00);
        bus(1'b1, 1'b0, 8'h77, 1'b1, q);
        chk("R10 tx_byte", tx_byte, 8'h77);
        chk("R10 tx_wr pulse", {7'd0, seen_tx_wr}, 8'h01);
        chk("R13 irq released by data write", {7'd0, irq_n}, 8'h01);
        rd_stat(q);
        chk("R10 status after write", q, 8'h00);
        @(negedge clk); tx_taken = 1'b1;
        @(negedge clk); tx_taken = 1'b0;
        rd_stat(q);
        chk("R10 status after tx_taken", q, 8'h82);

        // clear-to-send mask (R7)
        @(negedge clk); cts_n = 1'b1;
        @(negedge clk);
        rd_stat(q);
        chk("R7 cts high status", q, 8'h08);
        chk("R7 cts high irq_n", {7'd0, irq_n}, 8'h01);
        @(negedge clk); cts_n = 1'b0;
        wr_ctrl(8'h80);

        // carrier loss latch (R8)
        settle(1'b1);
        chk("R8 irq on carrier loss", {7'd0, irq_n}, 8'h00);
        settle(1'b0);
        bus(1'b1, 1'b1, 8'h00, 1'b1, q);
        rd_stat(q);
        chk("R8 latch survives data read alone", q, 8'h86);
        bus(1'b1, 1'b1, 8'h00, 1'b1, q);
        rd_stat(q);
        chk("R8 cleared after status then data", q, 8'h02);
        chk("R8 irq released", {7'd0, irq_n}, 8'h01);
        settle(1'b1);
        rd_stat(q);
        bus(1'b1, 1'b1, 8'h00, 1'b1, q);
        rd_stat(q);
        chk("R8 follows input after clear", q, 8'h06);
        chk("R8 no irq while following", {7'd0, irq_n}, 8'h01);
        settle(1'b0);
        rd_stat(q);
        chk("R8 input back low", q, 8'h02);

        // master reset with overrun and cts high (R11)
        rx_push(8'h11, 1'b0, 1'b0);
        rx_push(8'h22, 1'b0, 1'b0);
        @(negedge clk); cts_n = 1'b1;
        wr_ctrl(8'h03);
        rd_stat(q);
        chk("R11 master reset keeps cts bit", q, 8'h08);
        @(negedge clk); cts_n = 1'b0;
        @(negedge clk);
        rd_stat(q);
        chk("R11 status after cts low", q, 8'h02);

        done = 1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule